// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the command-path front end of an SD/MMC host controller. Software first loads a 32-bit argument, then writes a 16-bit command word. That write launches the command toward a CMD-line serializer, which is modelled here as a simple handshake: a one-cycle start pulse goes out, and a done pulse comes back together with the received response frame. CRC7 generation and the DAT-line transfer engine live elsewhere.

Before issuing anything, software polls two inhibit flags in a present-state word. The command inhibit covers the CMD line. The data inhibit covers the DAT lines and is needed by commands that carry data or wait for busy. When the command completes, the unit stores the response. A short response keeps its 32-bit payload. A long response keeps 120 bits, with the CRC byte removed, across four 32-bit words. A one-cycle completion pulse goes to the interrupt logic.

For busy-type commands, completion is held back until the card releases DAT0. The DAT line levels are mirrored into the present-state word.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, both inhibit flags, `ser_start`, `cmd_cmplt`, `idx_err` and all 128 bits of `resp_out` are 0.
- R2: An accepted write of `cmd_wdata` produces a one-cycle `ser_start` on the following cycle. Alongside it, `ser_index` takes bits 13:8, `ser_kind` takes bits 1:0 and `ser_crc_chk` takes bit 3. `ser_arg` takes the argument value held before the command write; an argument write in the same cycle, or during the command, does not reach `ser_arg`.
- R3: The command inhibit (`prsnt_state` bit 0) is set by an accepted command and cleared on the edge that raises `cmd_cmplt`. A command write while it is set is ignored and produces no `ser_start`.
- R4: The data inhibit (`prsnt_state` bit 1) is set by an accepted command whose data-present bit 5 is 1 or whose kind code is 11. A command needing DAT while the data inhibit is set is ignored. A command needing neither is accepted regardless of the data inhibit.
- R5: A `xfer_done` pulse clears the data inhibit left by a data command.
- R6: Kind code 01 (long response): on the `ser_done` edge, `resp_out` becomes 8 zero bits followed by `ser_resp[127:8]`.
- R7: Kind code 10 (short response): on the `ser_done` edge, `resp_out[31:0]` becomes `ser_resp[39:8]` and `resp_out[127:32]` keeps its value.
- R8: Kind code 00 (no response): `cmd_cmplt` pulses on the `ser_done` edge and `resp_out` is unchanged.
- R9: Kind code 11 (short response with busy): the response is stored on the `ser_done` edge. `cmd_cmplt` is raised, and both inhibits are cleared, only on the edge where `dat_lines[0]` is sampled high.
- R10: `prsnt_state[23:20]` mirrors `dat_lines[3:0]`; all unlisted bits of `prsnt_state` read 0.
- R11: With index check (bit 4) enabled and kind 10 or 11, `idx_err` pulses on the response-storing edge when `ser_resp[45:40]` differs from the issued index. It stays 0 when the indices match or the check is off.
- R12: `cmd_cmplt` and `idx_err` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_wr | input | 1 | Command register write strobe (launches) |
| cmd_wdata | input | 16 | Command word |
| dat_lines | input | 4 | DAT[3:0] line levels |
| xfer_done | input | 1 | End-of-transfer pulse from the data engine |
| ser_start | output | 1 | Start pulse to the CMD serializer |
| ser_index | output | 6 | Command index being issued |
| ser_arg | output | 32 | Argument being issued |
| ser_kind | output | 2 | Response kind code of the issued command |
| ser_crc_chk | output | 1 | CRC check enable for the serializer |
| ser_done | input | 1 | Serializer finished pulse |
| ser_resp | input | 136 | Received response frame (short frames in bits 47:0) |
| resp_out | output | 128 | Stored response words |
| cmd_cmplt | output | 1 | Command complete pulse |
| idx_err | output | 1 | Response index mismatch pulse |
| prsnt_state | output | 32 | Present state: inhibits and DAT levels |

## Verification
Commands are issued with each of the four response kind codes. Each kind is paired with a response frame whose payload is distinctive enough to show bit placement. A long response followed by a short one shows whether the CRC byte is dropped and whether the upper words survive a short capture.

Command writes arrive while each inhibit flag is set, in three cases: with a data command, with a non-data command, and with an argument write in the same cycle. These cases separate acceptance from rejection and tell which argument reaches the serializer.

A busy command held with DAT0 low for several cycles shows that completion waits for the line. Index-check runs with matching and mismatching echoes, and with the check turned off, separate the error pulse from ordinary completion.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CmdW     = 16;
  localparam int IdxW     = 6;
  localparam int ArgW     = 32;
  localparam int RespW    = 128;
  localparam int FrameW   = 136;
  localparam int CrcStrip = 8;
  localparam int PresW    = 32;
  localparam int DatW     = 4;
  localparam int DatPos   = 20;
  localparam int IdxPos   = 8;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_LONG  = 2'b01,
    RSP_SHORT = 2'b10,
    RSP_BUSY  = 2'b11
  } rsp_kind_e;

  typedef struct packed {
    logic [IdxW-1:0] idx;
    logic            data_pres;
    logic            idx_chk;
    logic            crc_chk;
    rsp_kind_e       kind;
  } cmd_fields_t;

  function automatic cmd_fields_t unpack_cmd(input logic [CmdW-1:0] w);
    cmd_fields_t f;
    f.idx       = w[IdxPos +: IdxW];
    f.data_pres = w[5];
    f.idx_chk   = w[4];
    f.crc_chk   = w[3];
    f.kind      = rsp_kind_e'(w[1:0]);
    return f;
  endfunction

  function automatic logic needs_dat(input cmd_fields_t f);
    return f.data_pres || (f.kind == RSP_BUSY);
  endfunction

  // long frame: drop the 8 header bits on top and the CRC byte at the bottom
  function automatic logic [RespW-1:0] long_payload(input logic [FrameW-1:0] fr);
    return {{CrcStrip{1'b0}}, fr[RespW-1:CrcStrip]};
  endfunction

  function automatic logic [ArgW-1:0] short_payload(input logic [FrameW-1:0] fr);
    return fr[CrcStrip +: ArgW];
  endfunction

  function automatic logic [IdxW-1:0] echo_idx(input logic [FrameW-1:0] fr);
    return fr[CrcStrip+ArgW +: IdxW];
  endfunction
endpackage

// File: rtl/sd_cmd_decode.sv
module sd_cmd_decode
  import sdc_pkg::*;
(
  input  logic [CmdW-1:0] cmd_word,
  output cmd_fields_t     fields,
  output logic            dat_need
);
  always_comb begin
    fields   = unpack_cmd(cmd_word);
    dat_need = needs_dat(fields);
  end
endmodule

// File: rtl/sd_inhibit_flags.sv
module sd_inhibit_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cmd,
  input  logic set_dat,
  input  logic clr_cmd,
  input  logic clr_dat,
  output logic cmd_inh,
  output logic dat_inh
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_inh <= 1'b0;
      dat_inh <= 1'b0;
    end else begin
      if (set_cmd)      cmd_inh <= 1'b1;
      else if (clr_cmd) cmd_inh <= 1'b0;
      if (set_dat)      dat_inh <= 1'b1;
      else if (clr_dat) dat_inh <= 1'b0;
    end
  end
endmodule

// File: rtl/sd_resp_capture.sv
module sd_resp_capture
  import sdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  rsp_kind_e         kind,
  input  logic [FrameW-1:0] frame,
  output logic [RespW-1:0]  resp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_q <= '0;
    end else if (cap_en) begin
      if (kind == RSP_LONG) resp_q <= long_payload(frame);
      else                  resp_q[ArgW-1:0] <= short_payload(frame);
    end
  end

  // R8: without a capture strobe the stored words stay put
  a_r8_hold_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(resp_q));
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arg_wr,
  input  logic [ArgW-1:0]   arg_wdata,
  input  logic              cmd_wr,
  input  logic [CmdW-1:0]   cmd_wdata,
  input  logic [DatW-1:0]   dat_lines,
  input  logic              xfer_done,
  output logic              ser_start,
  output logic [IdxW-1:0]   ser_index,
  output logic [ArgW-1:0]   ser_arg,
  output logic [1:0]        ser_kind,
  output logic              ser_crc_chk,
  input  logic              ser_done,
  input  logic [FrameW-1:0] ser_resp,
  output logic [RespW-1:0]  resp_out,
  output logic              cmd_cmplt,
  output logic              idx_err,
  output logic [PresW-1:0]  prsnt_state
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BUSY} phase_e;

  phase_e          state_q;
  cmd_fields_t     new_f, fields_q;
  logic            new_dat_need;
  logic [ArgW-1:0] arg_q, arg_launch_q;
  logic            cmd_inh, dat_inh;

  // named events
  logic launch_evt, resp_evt, busy_end, done_evt, cap_en, idx_bad;

  sd_cmd_decode u_dec (
    .cmd_word (cmd_wdata),
    .fields   (new_f),
    .dat_need (new_dat_need)
  );

  assign launch_evt = cmd_wr && !cmd_inh && !(new_dat_need && dat_inh);
  assign resp_evt   = (state_q == S_WAIT) && ser_done;
  assign busy_end   = (state_q == S_BUSY) && dat_lines[0];
  assign done_evt   = (resp_evt && fields_q.kind != RSP_BUSY) || busy_end;
  assign cap_en     = resp_evt && fields_q.kind != RSP_NONE;
  assign idx_bad    = resp_evt && fields_q.idx_chk &&
                      (fields_q.kind == RSP_SHORT || fields_q.kind == RSP_BUSY) &&
                      (echo_idx(ser_resp) != fields_q.idx);

  sd_inhibit_flags u_inh (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_cmd (launch_evt),
    .set_dat (launch_evt && new_dat_need),
    .clr_cmd (done_evt),
    .clr_dat (busy_end || (xfer_done && state_q != S_BUSY)),
    .cmd_inh (cmd_inh),
    .dat_inh (dat_inh)
  );

  sd_resp_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .kind   (fields_q.kind),
    .frame  (ser_resp),
    .resp_q (resp_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      fields_q     <= '0;
      arg_q        <= '0;
      arg_launch_q <= '0;
      ser_start    <= 1'b0;
      cmd_cmplt    <= 1'b0;
      idx_err      <= 1'b0;
    end else begin
      ser_start <= launch_evt;
      cmd_cmplt <= done_evt;
      idx_err   <= idx_bad;
      if (arg_wr) arg_q <= arg_wdata;
      case (state_q)
        S_IDLE: if (launch_evt) begin
          state_q      <= S_WAIT;
          fields_q     <= new_f;
          arg_launch_q <= arg_q;
        end
        S_WAIT: if (ser_done)
          state_q <= (fields_q.kind == RSP_BUSY) ? S_BUSY : S_IDLE;
        S_BUSY: if (dat_lines[0]) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ser_index   = fields_q.idx;
  assign ser_arg     = arg_launch_q;
  assign ser_kind    = fields_q.kind;
  assign ser_crc_chk = fields_q.crc_chk;
  assign prsnt_state = {{(PresW-DatPos-DatW){1'b0}}, dat_lines,
                        {(DatPos-2){1'b0}}, dat_inh, cmd_inh};

  // R2: start is a single-cycle pulse
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |=> !ser_start);
  // R3: a start is always covered by the command inhibit
  a_r3_start_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |-> cmd_inh);
  // R3: a write during an open command launches nothing
  a_r3_no_launch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_inh) |=> !ser_start);
  // R3: completion leaves the CMD line free
  a_r3_cmplt_frees_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cmplt |-> !cmd_inh);
  // R4: data inhibit only rises together with a launch
  a_r4_dat_rise_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_inh) |-> ser_start);
  // R9: while DAT0 is low in the busy phase nothing completes
  a_r9_busy_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BUSY && !dat_lines[0]) |=> (!cmd_cmplt && cmd_inh));
  // R12: pulses last one cycle
  a_r12_cmplt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cmplt |=> !cmd_cmplt);
  a_r12_idx_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |=> !idx_err);
endmodule

// File: tb/test_sd_cmd_issue.sv
`timescale 1ns/100ps
module test_sd_cmd_issue;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         arg_wr = 1'b0;
  logic [31:0]  arg_wdata = '0;
  logic         cmd_wr = 1'b0;
  logic [15:0]  cmd_wdata = '0;
  logic [3:0]   dat_lines = 4'hF;
  logic         xfer_done = 1'b0;
  logic         ser_start;
  logic [5:0]   ser_index;
  logic [31:0]  ser_arg;
  logic [1:0]   ser_kind;
  logic         ser_crc_chk;
  logic         ser_done = 1'b0;
  logic [135:0] ser_resp = '0;
  logic [127:0] resp_out;
  logic         cmd_cmplt;
  logic         idx_err;
  logic [31:0]  prsnt_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sd_cmd_issue i_sd_cmd_issue (.*);

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cmd(input logic [5:0] idx, input logic dp,
                                         input logic ic, input logic cc, input logic [1:0] k);
    return {2'b00, idx, 2'b00, dp, ic, cc, 1'b0, k};
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] pl);
    return {88'h0, 2'b00, idx, pl, 7'h55, 1'b1};
  endfunction

  task automatic wr_arg(input logic [31:0] v);
    arg_wr = 1'b1; arg_wdata = v;
    @(negedge clk); arg_wr = 1'b0;
  endtask

  task automatic wr_cmd(input logic [15:0] w);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic finish_ser(input logic [135:0] fr);
    ser_done = 1'b1; ser_resp = fr;
    @(negedge clk); ser_done = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 cmd_inh", prsnt_state[0], 0);
    check("R1 dat_inh", prsnt_state[1], 0);
    check("R1 ser_start", ser_start, 0);
    check("R1 cmplt", cmd_cmplt, 0);
    check("R1 idx_err", idx_err, 0);
    check("R1 resp", resp_out, 0);
  endtask

  task automatic t_short;
    wr_arg(32'hCAFE_0001);
    wr_cmd(mk_cmd(6'd17, 0, 1, 1, 2'b10));
    check("R2 start", ser_start, 1);
    check("R2 index", ser_index, 17);
    check("R2 kind", ser_kind, 2);
    check("R2 crc", ser_crc_chk, 1);
    check("R2 arg", ser_arg, 32'hCAFE_0001);
    check("R3 cmd_inh set", prsnt_state[0], 1);
    check("R4 no dat_inh", prsnt_state[1], 0);
    @(negedge clk);
    check("R2 start one cycle", ser_start, 0);
    wr_cmd(mk_cmd(6'd5, 0, 0, 0, 2'b10));
    check("R3 ignored while inhibited", ser_start, 0);
    check("R3 index kept", ser_index, 17);
    finish_ser(mk_short(6'd17, 32'h1234_5678));
    check("R7 short payload", resp_out[31:0], 32'h1234_5678);
    check("R7 cmplt", cmd_cmplt, 1);
    check("R11 match no err", idx_err, 0);
    check("R3 cmd_inh cleared", prsnt_state[0], 0);
    @(negedge clk);
    check("R12 cmplt single", cmd_cmplt, 0);
  endtask

  task automatic t_long_then_short;
    wr_cmd(mk_cmd(6'd2, 0, 0, 1, 2'b01));
    check("R2 kind long", ser_kind, 1);
    @(negedge clk);
    finish_ser(136'h3F_112233445566778899AABBCCDDEEFF_A5);
    check("R6 long stored", resp_out, 128'h00112233445566778899AABBCCDDEEFF);
    check("R6 cmplt", cmd_cmplt, 1);
    wr_cmd(mk_cmd(6'd13, 0, 0, 0, 2'b10));
    finish_ser(mk_short(6'd13, 32'hDEAD_BEEF));
    check("R7 upper kept", resp_out, 128'h00112233445566778899AABBDEADBEEF);
  endtask

  task automatic t_none;
    wr_cmd(mk_cmd(6'd0, 0, 0, 0, 2'b00));
    @(negedge clk);
    finish_ser(mk_short(6'd9, 32'h0BAD_0BAD));
    check("R8 cmplt", cmd_cmplt, 1);
    check("R8 resp unchanged", resp_out, 128'h00112233445566778899AABBDEADBEEF);
    check("R8 cmd_inh cleared", prsnt_state[0], 0);
  endtask

  task automatic t_data;
    wr_cmd(mk_cmd(6'd18, 1, 0, 0, 2'b10));
    check("R4 dat_inh set by data", prsnt_state[1], 1);
    finish_ser(mk_short(6'd18, 32'h0000_0900));
    check("R4 cmd free, dat held", prsnt_state[1:0], 2'b10);
    wr_cmd(mk_cmd(6'd24, 1, 0, 0, 2'b10));
    check("R4 data cmd ignored", ser_start, 0);
    check("R4 still free", prsnt_state[0], 0);
    wr_cmd(mk_cmd(6'd12, 0, 0, 0, 2'b10));
    check("R4 non-data accepted", ser_start, 1);
    check("R4 non-data index", ser_index, 12);
    finish_ser(mk_short(6'd12, 32'h7));
    check("R4 dat still held", prsnt_state[1], 1);
    xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    check("R5 dat cleared", prsnt_state[1], 0);
  endtask

  task automatic t_busy;
    dat_lines = 4'hE;
    @(negedge clk);
    check("R10 dat mirror", prsnt_state[23:20], 4'hE);
    check("R10 other bits", {prsnt_state[31:24], prsnt_state[19:2]}, 0);
    wr_cmd(mk_cmd(6'd7, 0, 1, 1, 2'b11));
    check("R4 busy sets dat", prsnt_state[1:0], 2'b11);
    finish_ser(mk_short(6'd7, 32'hA5A5_0007));
    check("R9 resp stored", resp_out[31:0], 32'hA5A5_0007);
    check("R9 no cmplt yet", cmd_cmplt, 0);
    check("R11 busy match", idx_err, 0);
    repeat (3) @(negedge clk);
    check("R9 held inhibits", prsnt_state[1:0], 2'b11);
    check("R9 still no cmplt", cmd_cmplt, 0);
    dat_lines = 4'hF;
    @(negedge clk);
    check("R9 cmplt on DAT0", cmd_cmplt, 1);
    check("R9 inhibits clear", prsnt_state[1:0], 2'b00);
    check("R10 dat mirror F", prsnt_state[23:20], 4'hF);
  endtask

  task automatic t_idx;
    wr_cmd(mk_cmd(6'd9, 0, 1, 0, 2'b10));
    finish_ser(mk_short(6'd10, 32'h1));
    check("R11 mismatch err", idx_err, 1);
    check("R11 with cmplt", cmd_cmplt, 1);
    @(negedge clk);
    check("R12 idx_err single", idx_err, 0);
    wr_cmd(mk_cmd(6'd9, 0, 0, 0, 2'b10));
    finish_ser(mk_short(6'd10, 32'h2));
    check("R11 check off", idx_err, 0);
  endtask

  task automatic t_arg;
    wr_arg(32'h1111_1111);
    arg_wr = 1'b1; arg_wdata = 32'h2222_2222;
    cmd_wr = 1'b1; cmd_wdata = mk_cmd(6'd3, 0, 0, 0, 2'b10);
    @(negedge clk); arg_wr = 1'b0; cmd_wr = 1'b0;
    check("R2 same-cycle arg not used", ser_arg, 32'h1111_1111);
    wr_arg(32'h3333_3333);
    check("R2 arg stable during cmd", ser_arg, 32'h1111_1111);
    finish_ser(mk_short(6'd3, 32'h3));
    wr_cmd(mk_cmd(6'd4, 0, 0, 0, 2'b10));
    check("R2 latest arg used", ser_arg, 32'h3333_3333);
    finish_ser(mk_short(6'd4, 32'h4));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_short();
    t_long_then_short();
    t_none();
    t_data();
    t_busy();
    t_idx();
    t_arg();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule